// File: doc/BRIEF.md
# Dual-Port Ratio RAM

This block is a synchronous two-port memory of 16384 data bits plus 2048 parity bits. Each port has its own clock, enable, write enable, address, write data and registered read data. A port's word width is fixed at elaboration from the set 1, 2, 4, 9 and 18 bits. Both ports see the same bits, so a word written through one port can be read through the other at a different width.

The 9-bit and 18-bit shapes carry one and two parity bits in a separate parity store. Each port also has its own fixed rule for what its read register shows during a write cycle:
- the old contents of the word,
- the incoming write data, or
- no change at all.

Storage uses two banks combined by XOR. Each bank is written by one port only, so the two clock domains never drive the same register. When both ports write overlapping bits on the same clock edge, port B's value is stored. An unsupported width stops elaboration.

Top module: `dual_ratio_ram`

## Requirements
- R1: Width 1, 2, 4, 9 or 18 gives 16384, 8192, 4096, 2048 or 1024 words and an address of 14, 13, 12, 11 or 10 bits. The highest address reaches its own word and does not alias word 0.
- R2: A port with D data bits and P parity bits keeps data bit i of word A at data-store bit A*D+i, and parity bit j at parity-store bit A*P+j. On 9-bit and 18-bit ports the parity sits in the top of the word: bit 8, or bits 17:16.
- R3: Data written through one port at one width reads back through the other port at its own width, following the R2 placement.
- R4: Parity written at 18 bits reads back at 9 bits, and the reverse, following the R2 placement.
- R5: Read data is registered. It changes only on the clock edge that ends an enabled cycle and shows the word addressed in that cycle. A new address does not change the output before that edge.
- R6: With enable low, a port writes nothing and its read register keeps its value, whatever write enable shows.
- R7: In old-data mode, a write cycle loads the read register with the word's contents from before the write, and the new data is stored.
- R8: In new-data mode, a write cycle loads the read register with the write data on the same edge that stores it.
- R9: In hold mode, a write cycle leaves the read register unchanged. Only enabled read cycles update it.
- R10: A synchronous active-high reset clears both read registers and every storage bit.
- R11: When both ports write on the same edge, bits covered by both writes take port B's value. Port A's other bits are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| en_a | input | 1 | Port A cycle enable |
| we_a | input | 1 | Port A write enable, used when en_a is high |
| addr_a | input | AW_A (11 by default) | Port A word address |
| wdata_a | input | WIDTH_A (9 by default) | Port A write word, parity in the top bits |
| rdata_a | output | WIDTH_A (9 by default) | Port A registered read word |
| en_b | input | 1 | Port B cycle enable |
| we_b | input | 1 | Port B write enable, used when en_b is high |
| addr_b | input | AW_B (10 by default) | Port B word address |
| wdata_b | input | WIDTH_B (18 by default) | Port B write word, parity in the top bits |
| rdata_b | output | WIDTH_B (18 by default) | Port B registered read word |

## Verification
A wrong bit in either bank stays hidden until some port reads a word covering that bit. It then shows one edge later, at whichever width that port uses. For that reason the bench reads every written word back at a second width and at the edges of the address range. A read-register fault, such as the wrong mode, a missing enable gate or a missed reset, shows on the edge right after the cycle that caused it. The bench and the in-module properties compare the output on that edge.

// File: rtl/dpram_shape_pkg.sv
package dpram_shape_pkg;

  localparam int DATA_STORE_BITS = 16384;
  localparam int PAR_STORE_BITS  = 2048;

  // read-register behaviour during a write cycle
  typedef enum logic [1:0] {
    OUT_OLD  = 2'd0,
    OUT_NEW  = 2'd1,
    OUT_HOLD = 2'd2
  } wmode_e;

  function automatic bit width_ok(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
  endfunction

  function automatic int data_w(int w);
    return (w == 9) ? 8 : (w == 18) ? 16 : w;
  endfunction

  function automatic int par_w(int w);
    return w - data_w(w);
  endfunction

  function automatic int addr_w(int w);
    return $clog2(DATA_STORE_BITS / data_w(w));
  endfunction

endpackage

// File: rtl/clash_mask.sv
// Marks the bits of this port's write word that the peer port also writes
// on the same edge; those bits are left to the peer.
module clash_mask #(
  parameter int SEG_M = 8,
  parameter int SEG_P = 16,
  parameter int IW_M  = 11,
  parameter int IW_P  = 10
) (
  input  logic [IW_M-1:0]  my_idx,
  input  logic [IW_P-1:0]  peer_idx,
  input  logic             peer_wr,
  output logic [SEG_M-1:0] mask
);

  always_comb begin
    int lo;
    int pos;
    lo = int'(peer_idx) * SEG_P;
    for (int i = 0; i < SEG_M; i++) begin
      pos     = int'(my_idx) * SEG_M + i;
      mask[i] = peer_wr && (pos >= lo) && (pos < lo + SEG_P);
    end
  end

endmodule

// File: rtl/xor_bank.sv
// One port's private bank. Stored value = new bits XOR peer bank, so the
// XOR of both banks yields the last written value.
module xor_bank #(
  parameter int TOTAL = 16384,
  parameter int SEG   = 8,
  localparam int IW   = $clog2(TOTAL / SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [SEG-1:0]   wbits,
  input  logic [SEG-1:0]   skip,
  input  logic [TOTAL-1:0] peer,
  output logic [TOTAL-1:0] bank
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
    end else if (we) begin
      for (int i = 0; i < SEG; i++) begin
        if (!skip[i]) begin
          bank[int'(idx) * SEG + i] <= wbits[i] ^ peer[int'(idx) * SEG + i];
        end
      end
    end
  end

endmodule

// File: rtl/port_ctrl.sv
// Word extraction and the registered read output of one port.
module port_ctrl
  import dpram_shape_pkg::*;
#(
  parameter int     WIDTH = 9,
  parameter wmode_e MODE  = OUT_OLD,
  localparam int DW = data_w(WIDTH),
  localparam int PW = par_w(WIDTH),
  localparam int AW = addr_w(WIDTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic [DATA_STORE_BITS-1:0] dview,
  input  logic [PAR_STORE_BITS-1:0]  pview,
  output logic [WIDTH-1:0]           rdata
);

  logic [WIDTH-1:0] cur;
  logic unused_sink;
  assign unused_sink = ^{wdata, pview};

  generate
    if (PW > 0) begin : g_par
      always_comb cur = {pview[int'(addr) * PW +: PW], dview[int'(addr) * DW +: DW]};
    end else begin : g_nopar
      always_comb cur = dview[int'(addr) * DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (en) begin
      if (!we) begin
        rdata <= cur;
      end else begin
        case (MODE)
          OUT_OLD:  rdata <= cur;
          OUT_NEW:  rdata <= wdata;
          default:  rdata <= rdata;
        endcase
      end
    end
  end

  // R10
  clear_on_rst_chk: assert property (@(posedge clk) rst |=> rdata == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rdata));

  generate
    if (MODE == OUT_NEW) begin : g_new_chk
      // R8
      echo_new_chk: assert property (@(posedge clk) disable iff (rst)
        en && we |=> rdata == $past(wdata));
    end
    if (MODE == OUT_HOLD) begin : g_hold_chk
      // R9
      hold_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        en && we |=> $stable(rdata));
    end
  endgenerate

endmodule

// File: rtl/dual_ratio_ram.sv
module dual_ratio_ram
  import dpram_shape_pkg::*;
#(
  parameter int     WIDTH_A = 9,
  parameter int     WIDTH_B = 18,
  parameter wmode_e MODE_A  = OUT_OLD,
  parameter wmode_e MODE_B  = OUT_NEW,
  localparam int DW_A = data_w(WIDTH_A),
  localparam int DW_B = data_w(WIDTH_B),
  localparam int PW_A = par_w(WIDTH_A),
  localparam int PW_B = par_w(WIDTH_B),
  localparam int AW_A = addr_w(WIDTH_A),
  localparam int AW_B = addr_w(WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               clk_b,
  input  logic               rst,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] wdata_a,
  output logic [WIDTH_A-1:0] rdata_a,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] wdata_b,
  output logic [WIDTH_B-1:0] rdata_b
);

  generate
    if (!width_ok(WIDTH_A) || !width_ok(WIDTH_B)) begin : g_bad_width
      $error("dual_ratio_ram: port width must be 1, 2, 4, 9 or 18");
    end
  endgenerate

  logic [DATA_STORE_BITS-1:0] dbank_a, dbank_b, dview;
  logic [PAR_STORE_BITS-1:0]  pbank_a, pbank_b, pview;
  logic [DW_A-1:0]            dskip_a;
  logic                       wr_a, wr_b;

  assign wr_a  = en_a & we_a;
  assign wr_b  = en_b & we_b;
  assign dview = dbank_a ^ dbank_b;
  assign pview = pbank_a ^ pbank_b;

  // port B wins on shared bits: port A leaves them untouched
  clash_mask #(.SEG_M(DW_A), .SEG_P(DW_B), .IW_M(AW_A), .IW_P(AW_B)) u_dclash (
    .my_idx(addr_a), .peer_idx(addr_b), .peer_wr(wr_b), .mask(dskip_a)
  );

  xor_bank #(.TOTAL(DATA_STORE_BITS), .SEG(DW_A)) u_dbank_a (
    .clk(clk_a), .rst(rst), .we(wr_a), .idx(addr_a), .wbits(wdata_a[DW_A-1:0]),
    .skip(dskip_a), .peer(dbank_b), .bank(dbank_a)
  );

  xor_bank #(.TOTAL(DATA_STORE_BITS), .SEG(DW_B)) u_dbank_b (
    .clk(clk_b), .rst(rst), .we(wr_b), .idx(addr_b), .wbits(wdata_b[DW_B-1:0]),
    .skip('0), .peer(dbank_a), .bank(dbank_b)
  );

  generate
    if (PW_A > 0) begin : g_par_a
      logic [PW_A-1:0] pskip;
      if (PW_B > 0) begin : g_pclash
        clash_mask #(.SEG_M(PW_A), .SEG_P(PW_B), .IW_M(AW_A), .IW_P(AW_B)) u_pclash (
          .my_idx(addr_a), .peer_idx(addr_b), .peer_wr(wr_b), .mask(pskip)
        );
      end else begin : g_nopclash
        assign pskip = '0;
      end
      xor_bank #(.TOTAL(PAR_STORE_BITS), .SEG(PW_A)) u_pbank_a (
        .clk(clk_a), .rst(rst), .we(wr_a), .idx(addr_a),
        .wbits(wdata_a[WIDTH_A-1:DW_A]), .skip(pskip), .peer(pbank_b), .bank(pbank_a)
      );
    end else begin : g_nopar_a
      assign pbank_a = '0;
    end

    if (PW_B > 0) begin : g_par_b
      xor_bank #(.TOTAL(PAR_STORE_BITS), .SEG(PW_B)) u_pbank_b (
        .clk(clk_b), .rst(rst), .we(wr_b), .idx(addr_b),
        .wbits(wdata_b[WIDTH_B-1:DW_B]), .skip('0), .peer(pbank_a), .bank(pbank_b)
      );
    end else begin : g_nopar_b
      assign pbank_b = '0;
    end
  endgenerate

  port_ctrl #(.WIDTH(WIDTH_A), .MODE(MODE_A)) u_port_a (
    .clk(clk_a), .rst(rst), .en(en_a), .we(we_a), .addr(addr_a), .wdata(wdata_a),
    .dview(dview), .pview(pview), .rdata(rdata_a)
  );

  port_ctrl #(.WIDTH(WIDTH_B), .MODE(MODE_B)) u_port_b (
    .clk(clk_b), .rst(rst), .en(en_b), .we(we_b), .addr(addr_b), .wdata(wdata_b),
    .dview(dview), .pview(pview), .rdata(rdata_b)
  );

endmodule

// File: tb/dual_ratio_ram_test.sv
module dual_ratio_ram_test;
  import dpram_shape_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst;
  // uut: A 9-bit old-data, B 18-bit new-data
  logic ea, wa, eb, wb;
  logic [10:0] aa;  logic [8:0]  da, qa;
  logic [9:0]  ab;  logic [17:0] db, qb;
  // uut_n: A 1-bit hold, B 4-bit old-data
  logic nea, nwa, neb, nwb;
  logic [13:0] naa; logic [0:0] nda, nqa;
  logic [11:0] nab; logic [3:0] ndb, nqb;

  bit [16383:0] m0d, m1d;
  bit [2047:0]  m0p;
  logic [8:0]  e_qa;  logic [17:0] e_qb;
  logic [0:0]  e_nqa; logic [3:0]  e_nqb;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  dual_ratio_ram uut (
    .clk_a(clk), .clk_b(clk), .rst(rst),
    .en_a(ea), .we_a(wa), .addr_a(aa), .wdata_a(da), .rdata_a(qa),
    .en_b(eb), .we_b(wb), .addr_b(ab), .wdata_b(db), .rdata_b(qb)
  );

  dual_ratio_ram #(.WIDTH_A(1), .WIDTH_B(4), .MODE_A(OUT_HOLD), .MODE_B(OUT_OLD)) uut_n (
    .clk_a(clk), .clk_b(clk), .rst(rst),
    .en_a(nea), .we_a(nwa), .addr_a(naa), .wdata_a(nda), .rdata_a(nqa),
    .en_b(neb), .we_b(nwb), .addr_b(nab), .wdata_b(ndb), .rdata_b(nqb)
  );

  function automatic logic [17:0] peek0(int w, int a);
    int dw = (w == 9) ? 8 : 16;
    int pw = w - dw;
    logic [17:0] v = '0;
    for (int i = 0; i < dw; i++) v[i] = m0d[a*dw+i];
    for (int j = 0; j < pw; j++) v[dw+j] = m0p[a*pw+j];
    return v;
  endfunction

  task automatic poke0(int w, int a, logic [17:0] v);
    int dw = (w == 9) ? 8 : 16;
    int pw = w - dw;
    for (int i = 0; i < dw; i++) m0d[a*dw+i] = v[i];
    for (int j = 0; j < pw; j++) m0p[a*pw+j] = v[dw+j];
  endtask

  function automatic logic [17:0] peek1(int w, int a);
    logic [17:0] v = '0;
    for (int i = 0; i < w; i++) v[i] = m1d[a*w+i];
    return v;
  endfunction

  task automatic poke1(int w, int a, logic [17:0] v);
    for (int i = 0; i < w; i++) m1d[a*w+i] = v[i];
  endtask

  task automatic chk(string tag, string port, logic [17:0] got, logic [17:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s port %s: got=%h expected=%h", tag, port, got, exp);
    end
  endtask

  task automatic idle();
    ea = 0; wa = 0; aa = '0; da = '0;
    eb = 0; wb = 0; ab = '0; db = '0;
    nea = 0; nwa = 0; naa = '0; nda = '0;
    neb = 0; nwb = 0; nab = '0; ndb = '0;
  endtask

  task automatic sa(logic e, logic w, int a, logic [8:0] d);
    ea = e; wa = w; aa = a[10:0]; da = d;
  endtask
  task automatic sb(logic e, logic w, int a, logic [17:0] d);
    eb = e; wb = w; ab = a[9:0]; db = d;
  endtask
  task automatic na(logic e, logic w, int a, logic d);
    nea = e; nwa = w; naa = a[13:0]; nda = d;
  endtask
  task automatic nb(logic e, logic w, int a, logic [3:0] d);
    neb = e; nwb = w; nab = a[11:0]; ndb = d;
  endtask

  // one clock: model the edge, then compare all four outputs
  task automatic step(string tag);
    logic [17:0] oa, ob, ona, onb;
    oa  = peek0(9, int'(aa));
    ob  = peek0(18, int'(ab));
    ona = peek1(1, int'(naa));
    onb = peek1(4, int'(nab));
    if (ea) e_qa = oa[8:0];
    if (eb) e_qb = wb ? db : ob;
    if (nea && !nwa) e_nqa = ona[0:0];
    if (neb) e_nqb = onb[3:0];
    if (ea && wa) poke0(9, int'(aa), {9'b0, da});
    if (eb && wb) poke0(18, int'(ab), db);
    if (nea && nwa) poke1(1, int'(naa), {17'b0, nda});
    if (neb && nwb) poke1(4, int'(nab), {14'b0, ndb});
    @(negedge clk);
    chk(tag, "A", {9'b0, qa}, {9'b0, e_qa});
    chk(tag, "B", qb, e_qb);
    chk(tag, "nA", {17'b0, nqa}, {17'b0, e_nqa});
    chk(tag, "nB", {14'b0, nqb}, {14'b0, e_nqb});
    idle();
  endtask

  task automatic t_reset();
    step("R10");
    sa(1, 1, 5, 9'h1FF); nb(1, 1, 7, 4'hF); step("R10");
    rst = 1'b1; idle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m0d = '0; m1d = '0; m0p = '0;
    e_qa = '0; e_qb = '0; e_nqa = '0; e_nqb = '0;
    step("R10");
    sa(1, 0, 5, 0); nb(1, 0, 7, 0); step("R10");
  endtask

  task automatic t_latency();
    sa(1, 1, 12, 9'h0C3); step("R5");
    sa(1, 0, 12, 0);
    #1 chk("R5", "A", {9'b0, qa}, {9'b0, e_qa});
    step("R5");
  endtask

  task automatic t_enable();
    sa(0, 1, 20, 9'h1AA); sb(0, 1, 10, 18'h3FFFF);
    na(0, 1, 3, 1'b1); nb(0, 1, 3, 4'hF);
    step("R6");
    sa(1, 0, 20, 0); sb(1, 0, 10, 0); na(1, 0, 3, 0); nb(1, 0, 3, 0);
    step("R6");
  endtask

  task automatic t_read_first();
    sa(1, 1, 12, 9'h15A); nb(1, 1, 100, 4'h9); step("R7");
    sa(1, 0, 12, 0);      nb(1, 1, 100, 4'h6); step("R7");
    nb(1, 0, 100, 0); step("R7");
  endtask

  task automatic t_write_first();
    sb(1, 1, 300, 18'h2BEEF); step("R8");
    sb(1, 1, 301, 18'h10F0F); step("R8");
    sb(1, 0, 300, 0); step("R8");
  endtask

  task automatic t_no_change();
    na(1, 1, 50, 1'b1); step("R9");
    na(1, 0, 50, 0);    step("R9");
    na(1, 1, 50, 1'b0); step("R9");
    na(1, 0, 50, 0);    step("R9");
  endtask

  task automatic t_cross();
    sb(1, 1, 40, {2'b10, 16'hA55A}); step("R3");
    sa(1, 0, 80, 0); step("R4");
    sa(1, 0, 81, 0); step("R4");
    sa(1, 1, 82, {1'b1, 8'h3C}); step("R3");
    sa(1, 1, 83, {1'b0, 8'hC3}); step("R3");
    sb(1, 0, 41, 0); step("R4");
    nb(1, 1, 9, 4'b1010); step("R3");
    for (int k = 36; k < 40; k++) begin
      na(1, 0, k, 0); step("R3");
    end
    na(1, 1, 44, 1'b1); step("R3");
    nb(1, 0, 11, 0); step("R3");
  endtask

  task automatic t_range();
    sa(1, 1, 2047, 9'h1C7); step("R1");
    sb(1, 0, 1023, 0); step("R1");
    sa(1, 1, 0, 9'h055); step("R1");
    sb(1, 0, 0, 0); step("R1");
    sa(1, 0, 2047, 0); step("R1");
    na(1, 1, 16383, 1'b1); step("R1");
    nb(1, 0, 4095, 0); step("R1");
    nb(1, 1, 4095, 4'h7); step("R1");
    na(1, 0, 16383, 0); step("R1");
    na(1, 0, 16380, 0); step("R1");
    nb(1, 0, 0, 0); step("R1");
  endtask

  task automatic t_clash();
    sa(1, 1, 100, {1'b1, 8'h11}); sb(1, 1, 50, {2'b11, 16'h2222}); step("R11");
    sa(1, 0, 100, 0); step("R11");
    sa(1, 0, 101, 0); step("R11");
    sa(1, 1, 104, 9'h0AB); sb(1, 1, 53, 18'h01234); step("R11");
    sa(1, 0, 104, 0); step("R11");
    sb(1, 0, 53, 0); step("R11");
    sb(1, 0, 52, 0); step("R11");
    na(1, 1, 200, 1'b1); nb(1, 1, 50, 4'h0); step("R11");
    na(1, 0, 200, 0); step("R11");
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 400; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      if (seed[31]) sa(1, seed[30], 64 + int'(seed[3:0]), seed[20:12]);
      else          sb(1, seed[30], 32 + int'(seed[2:0]), {seed[29:12]});
      if (seed[28]) na(1, seed[27], 128 + int'(seed[8:4]), seed[11]);
      else          nb(1, seed[27], 32 + int'(seed[6:4]), seed[24:21]);
      step("R2");
    end
  endtask

  initial begin
    rst = 1'b1;
    idle();
    e_qa = '0; e_qb = '0; e_nqa = '0; e_nqb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_enable();
    t_read_first();
    t_write_first();
    t_no_change();
    t_cross();
    t_range();
    t_clash();
    t_sweep();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule